// File: doc/BRIEF.md
# Double-Buffered Crosspoint Route Controller

This block holds the control state of an eight-input, four-output analog switch matrix. A host programs one route at a time: it puts an input code on a 4-bit address bus and an output number on a 2-bit select, then pulses a write strobe. Each output has a staging entry that takes these writes. The active entries that drive the switches do not change while routes are being staged.

A commit strobe copies all staged routes into the active bank in one clock cycle, so every output switches at the same instant. An active-low clear opens every crosspoint and pulls every disable flag low. The clear does not touch the staging bank, so a later commit brings back the routing that was staged before the clear. In read mode the block drives the active route code of a selected output onto a readback port, together with an output-enable for the shared address pins.

All control pins are asynchronous. Each one passes through a synchronizer chain in the block's single clock domain, and the strobes act on edges of the synchronized copies.

Top module: `xpt_ctrl`

## Requirements
- R1: A qualified write updates only the staging entry of the selected output. `xpt_en` and `dis_n` stay unchanged until a commit.
- R2: A falling edge of `commit_n` copies all four staging entries into the active entries in the same clock cycle.
- R3: Route codes 0 to 7 connect input code+1, which sets bit `8*output + code` of `xpt_en`. A code with bit 3 set turns the output off.
- R4: A write strobe is ignored when `cs_n` is high, when `rd_sel` is high, or when `commit_n` is low while the strobe is low.
- R5: While `clr_n` is low, `xpt_en` is zero and `dis_n` is zero. After the clear, every active entry reads back as 4'b1000.
- R6: The clear leaves the staging entries unchanged, so a commit after the clear restores the staged routing.
- R7: `rb_oe` is high only when `cs_n` is low and `rd_sel` is high. `rb_addr` then carries the active code of the output picked by `out_sel`. At all other times both are zero.
- R8: `dis_n[o]` is high exactly when output o has an active route.
- R9: One input can be routed to several or all outputs at the same time. Each output carries at most one input.
- R10: When a commit edge and a write-completing strobe edge arrive in the same cycle, the commit loads the staging value from before that write.
- R11: The clear takes priority over commit. A commit pulse made entirely during the clear loads nothing.
- R12: A written code with bit 3 set is stored as 4'b1000 and reads back as 4'b1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| clr_n | input | 1 | Active-low clear of the active bank; also resets the synchronizers |
| cs_n | input | 1 | Active-low chip select |
| rd_sel | input | 1 | 1 = readback, 0 = write |
| wr_n | input | 1 | Write strobe; the rising edge captures the route |
| commit_n | input | 1 | Commit strobe; the falling edge loads the active bank |
| out_sel | input | 2 | Output number to write or read |
| in_code | input | 4 | Route code to write |
| xpt_en | output | 32 | Crosspoint enables, bit 8*output+input |
| dis_n | output | 4 | Active-low per-output disable flags |
| rb_oe | output | 1 | Output-enable for the shared address pins |
| rb_addr | output | 4 | Active route code read back |

## Verification
The bench builds the block with its defaults: eight inputs, four outputs and two synchronizer stages. This gives full 4-bit codes and therefore the off-code normalization case. It also gives a 32-bit enable vector, where every output group and the fan-out of one input to all four outputs can be checked against exact values. Because both strobes go through the same synchronizer depth, driving the write release and the commit edge on the same clock makes them meet in the same cycle. This makes the old-staging-value ordering directly observable.

// File: rtl/xpt_ctrl.sv
module xpt_ctrl #(
  parameter int N_IN        = 8,
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                               clk,
  input  logic                               clr_n,
  input  logic                               cs_n,
  input  logic                               rd_sel,
  input  logic                               wr_n,
  input  logic                               commit_n,
  input  logic [$clog2(N_OUT)-1:0]           out_sel,
  input  logic [$clog2(N_IN):0]              in_code,
  output logic [N_OUT*N_IN-1:0]              xpt_en,
  output logic [N_OUT-1:0]                   dis_n,
  output logic                               rb_oe,
  output logic [$clog2(N_IN):0]              rb_addr
);
  localparam int IW  = $clog2(N_IN);
  localparam int CW  = IW + 1;
  localparam int OW  = $clog2(N_OUT);
  localparam int BW  = 4 + OW + CW;
  localparam logic [CW-1:0] OFF = {1'b1, {IW{1'b0}}};
  // bundle: {cs_n, rd_sel, wr_n, commit_n, out_sel, in_code}
  localparam logic [BW-1:0] IDLE = {4'b1011, {(OW+CW){1'b0}}};

  logic [BW-1:0] sync_q [SYNC_STAGES];
  logic [BW-1:0] last_q;
  logic [BW-1:0] cur;
  logic [N_OUT-1:0][CW-1:0] stg_q, act_q;
  logic wr_rise, commit_fall;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= IDLE;
      last_q <= IDLE;
    end else begin
      sync_q[0] <= {cs_n, rd_sel, wr_n, commit_n, out_sel, in_code};
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
      last_q <= cur;
    end
  end

  assign cur = sync_q[SYNC_STAGES-1];

  assign wr_rise = cur[BW-3] & ~last_q[BW-3] & ~last_q[BW-1] & ~last_q[BW-2] & last_q[BW-4];
  assign commit_fall = ~cur[BW-4] & last_q[BW-4];

  always_ff @(posedge clk) begin
    if (wr_rise)
      stg_q[last_q[CW +: OW]] <= last_q[CW-1] ? OFF : last_q[CW-1:0];
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) act_q <= {N_OUT{OFF}};
    else if (commit_fall) act_q <= stg_q;
  end

  genvar o, i;
  generate
    for (o = 0; o < N_OUT; o++) begin : g_out
      assign dis_n[o] = clr_n & ~act_q[o][CW-1];
      for (i = 0; i < N_IN; i++) begin : g_in
        assign xpt_en[o*N_IN+i] = clr_n & ~act_q[o][CW-1] & (act_q[o][IW-1:0] == IW'(i));
      end
      // R9
      one_route_chk: assert property (@(posedge clk) disable iff (!clr_n)
        $onehot0(xpt_en[o*N_IN +: N_IN]));
      // R8
      dis_match_chk: assert property (@(posedge clk) disable iff (!clr_n)
        dis_n[o] == (|xpt_en[o*N_IN +: N_IN]));
    end
  endgenerate

  assign rb_oe   = ~cur[BW-1] & cur[BW-2];
  assign rb_addr = rb_oe ? act_q[cur[CW +: OW]] : '0;

  // R2
  commit_load_chk: assert property (@(posedge clk) disable iff (!clr_n)
    commit_fall |=> act_q == $past(stg_q));
  // R1
  stage_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !wr_rise |=> $stable(stg_q));
  // R12
  rb_off_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (rb_oe && rb_addr[CW-1]) |-> rb_addr == OFF);
  // R5
  always @(posedge clk) begin
    if (!clr_n) clr_out_chk: assert (xpt_en == '0 && dis_n == '0);
  end
endmodule

// File: tb/xpt_ctrl_tb.sv
module xpt_ctrl_tb;
  logic clk = 0, clr_n = 0, cs_n = 1, rd_sel = 0, wr_n = 1, commit_n = 1;
  logic [1:0] out_sel = 0;
  logic [3:0] in_code = 0;
  logic [31:0] xpt_en;
  logic [3:0] dis_n, rb_addr;
  logic rb_oe;
  int tests = 0, fails = 0;
  logic [3:0] stg_m [4];
  logic [3:0] act_m [4];

  always #5 clk = ~clk;

  xpt_ctrl u_dut (.clk(clk), .clr_n(clr_n), .cs_n(cs_n), .rd_sel(rd_sel), .wr_n(wr_n),
    .commit_n(commit_n), .out_sel(out_sel), .in_code(in_code), .xpt_en(xpt_en),
    .dis_n(dis_n), .rb_oe(rb_oe), .rb_addr(rb_addr));

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string tag, logic [31:0] a, logic [31:0] e);
    tests++;
    if (a !== e) begin fails++; $display("FAIL %s actual=%h expected=%h", tag, a, e); end
  endtask

  function automatic logic [31:0] exp_xpt();
    logic [31:0] v = 0;
    for (int o = 0; o < 4; o++) if (!act_m[o][3]) v[o*8 + act_m[o][2:0]] = 1'b1;
    return v;
  endfunction

  function automatic logic [3:0] exp_dis();
    logic [3:0] v;
    for (int o = 0; o < 4; o++) v[o] = !act_m[o][3];
    return v;
  endfunction

  task automatic chk_outs(string tag);
    chk({tag, " xpt_en"}, xpt_en, exp_xpt());
    chk({tag, " dis_n"}, {28'd0, dis_n}, {28'd0, exp_dis()});
  endtask

  task automatic do_write(int o, logic [3:0] code, logic csv, logic dirv);
    cs_n = csv; rd_sel = dirv; out_sel = 2'(o); in_code = code; wt(4);
    wr_n = 0; wt(4); wr_n = 1; wt(4); cs_n = 1; rd_sel = 0;
    if (!csv && !dirv) stg_m[o] = code[3] ? 4'b1000 : code;
  endtask

  task automatic do_commit();
    commit_n = 0; wt(4); commit_n = 1; wt(4);
    for (int o = 0; o < 4; o++) act_m[o] = stg_m[o];
  endtask

  task automatic readback(int o, logic [3:0] e, string tag);
    cs_n = 0; rd_sel = 1; out_sel = 2'(o); wt(4);
    chk({tag, " rb_oe"}, {31'd0, rb_oe}, 32'd1);
    chk({tag, " rb_addr"}, {28'd0, rb_addr}, {28'd0, e});
    cs_n = 1; rd_sel = 0; wt(4);
  endtask

  task automatic t_reset();
    for (int o = 0; o < 4; o++) act_m[o] = 4'b1000;
    wt(3);
    chk("R5 clr xpt", xpt_en, 0);
    chk("R5 clr dis", {28'd0, dis_n}, 0);
    clr_n = 1; wt(4);
    for (int o = 0; o < 4; o++) readback(o, 4'b1000, "R5 off code");
  endtask

  task automatic t_stage_commit();
    do_write(0, 4'd2, 0, 0); do_write(1, 4'd7, 0, 0);
    do_write(2, 4'hB, 0, 0); do_write(3, 4'd0, 0, 0);
    chk("R1 no change before commit", xpt_en, 0);
    do_commit();
    chk_outs("R2");
    chk("R3 bit map", xpt_en, 32'h0100_8004);
    chk("R8 dis", {28'd0, dis_n}, 32'b1011);
    readback(2, 4'b1000, "R12 normalized");
    readback(1, 4'd7, "R7 readback");
  endtask

  task automatic t_ignored();
    do_write(0, 4'd5, 1, 0);
    do_write(0, 4'd5, 0, 1);
    commit_n = 0; wt(4);
    do_write(0, 4'd5, 1, 1);
    cs_n = 0; out_sel = 0; in_code = 4'd5; wt(4); wr_n = 0; wt(4); wr_n = 1; wt(4);
    cs_n = 1; commit_n = 1; wt(4);
    do_commit();
    chk_outs("R4 ignored writes");
    cs_n = 1; rd_sel = 1; wt(4);
    chk("R7 no oe when deselected", {27'd0, rb_oe, rb_addr}, 0);
    rd_sel = 0; cs_n = 0; wt(4);
    chk("R7 no oe in write mode", {27'd0, rb_oe, rb_addr}, 0);
    cs_n = 1; wt(2);
  endtask

  task automatic t_fanout();
    for (int o = 0; o < 4; o++) do_write(o, 4'd4, 0, 0);
    do_commit();
    chk("R9 fan-out", xpt_en, 32'h1010_1010);
    chk("R9 dis", {28'd0, dis_n}, 32'hF);
  endtask

  task automatic t_reset_keep();
    do_write(0, 4'd1, 0, 0);
    clr_n = 0; wt(3);
    chk("R5 clr xpt again", xpt_en, 0);
    chk("R5 clr dis again", {28'd0, dis_n}, 0);
    clr_n = 1; wt(4);
    for (int o = 0; o < 4; o++) act_m[o] = 4'b1000;
    readback(0, 4'b1000, "R5 off after clr");
    do_commit();
    chk("R6 restore", xpt_en, 32'h1010_1002);
  endtask

  task automatic t_reset_prio();
    clr_n = 0; wt(2);
    commit_n = 0; wt(4); commit_n = 1; wt(4);
    clr_n = 1; wt(6);
    for (int o = 0; o < 4; o++) act_m[o] = 4'b1000;
    chk("R11 commit in clr", xpt_en, 0);
  endtask

  task automatic t_same_cycle();
    cs_n = 0; rd_sel = 0; out_sel = 3; in_code = 4'd6; wt(4);
    wr_n = 0; wt(4);
    wr_n = 1; commit_n = 0; wt(4);
    commit_n = 1; cs_n = 1; wt(4);
    for (int o = 0; o < 4; o++) act_m[o] = stg_m[o];
    stg_m[3] = 4'd6;
    chk("R10 old staging", xpt_en, 32'h1010_1002);
    do_commit();
    chk("R10 new on next commit", xpt_en, 32'h4010_1002);
  endtask

  initial begin
    #2000000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_stage_commit();
    t_ignored();
    t_fanout();
    t_reset_keep();
    t_reset_prio();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule